// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Masked Half-Word Writes

This block is a memory-mapped general-purpose I/O controller that serves four banks of pins. Banks 0, 2 and 3 carry 32 pins each, and bank 1 carries 22. Each bank holds three registers: an output value, a direction and an output enable. A pin drives its pad only when its direction bit and its output-enable bit are both 1. Pin inputs pass through a two-flop synchronizer, and software can read each bank's synchronized pin levels from a read-only location.

Software changes the output value through two write-only ports per bank. Each port covers one 16-bit half of the bank. A write to one of these ports carries a 16-bit mask in its upper half and 16 data bits in its lower half. A data bit is applied only where its mask bit is 0, so a single pin can be set or cleared in one bus write, with no read-modify-write and no effect on neighbouring pins.

The register port is a simple 32-bit request interface. A request is taken in any cycle where the valid input is high. A read is answered one cycle later with a response-valid pulse and the read data.

Top module: `gpio_ctrl`

## Requirements
- R1: A write to offset 8*N, for bank N from 0 to 3, updates output bits 15:0 of bank N. For each i from 0 to 15, wdata[i] replaces output bit i when wdata[16+i] is 0, and output bit i is kept when wdata[16+i] is 1. The new value appears on pin_out from the clock edge that accepts the write.
- R2: A write to offset 8*N+4 applies the same masking rule to output bits 31:16 of bank N. Data bit i and mask bit 16+i of wdata control output bit 16+i.
- R3: pin_out[32*N+i] always shows output bit i of bank N. pin_oe[32*N+i] is 1 exactly when direction bit i and output-enable bit i of bank N are both 1.
- R4: The direction register of bank N is at offset 0x204+0x40*N. It can be written and read back, and a bit value of 1 means output.
- R5: The output-enable register of bank N is at offset 0x208+0x40*N. It can be written and read back.
- R6: A read of offset 0x060+4*N returns the levels of pin_in[32*N+31 : 32*N] after a two-flop synchronizer. A level that is stable for three cycles before a read request is returned by that read.
- R7: Bits 31:22 of bank 1 are not implemented. In every bank-1 register and in the bank-1 pin-value read, these bits read as 0. Writes to them are ignored, and their pin_out and pin_oe bits stay 0.
- R8: Direction bits 7 and 8 of bank 0 are always 1. A write of 0 to them is ignored.
- R9: After reset, every output, direction and output-enable bit is 0, except the bank-0 direction bits named in R8. So pin_out and pin_oe are all 0.
- R10: A read of a masked-data offset or of any unmapped offset returns 0. A write to an unmapped offset or to a pin-value offset changes no state.
- R11: A read request gives rsp_valid=1 with its data in the next cycle. A write request, or a cycle with no request, gives rsp_valid=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in any cycle where it is high |
| req_write | input | 1 | 1 for a write and 0 for a read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| pin_in | input | 128 | Pad input levels, 32 per bank |
| pin_out | output | 128 | Pad output values, 32 per bank |
| pin_oe | output | 128 | Pad drive enables, 32 per bank |

## Verification
The hardest case to reach is a long series of masked writes whose masks overlap. In such a series, every earlier value of the bits under the mask must survive unchanged. A single directed write cannot show this, so the stimulus runs hundreds of random operations from a fixed seed. These mix random masks, both halves of every bank, direction and output-enable updates, and writes to read-only and unmapped offsets. After each operation the bench compares all 128 pin outputs and drive enables against its own model. Directed cases cover the bank-1 bits that are not implemented, the locked bank-0 direction bits, and the three-cycle path from an input pin to a read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned GP_BANKS  = 4;
  localparam int unsigned GP_WIDTH  = 32;
  localparam int unsigned GP_ADDR_W = 12;

  // number of pins implemented in a bank
  function automatic int unsigned bank_pins(int unsigned b);
    return (b == 1) ? 22 : 32;
  endfunction

  // one bit per implemented pin
  function automatic logic [GP_WIDTH-1:0] impl_mask(int unsigned b);
    logic [GP_WIDTH-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < GP_WIDTH; i++) begin
      if (i < bank_pins(b)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // direction bits that are locked to output
  function automatic logic [GP_WIDTH-1:0] fixed_dir(int unsigned b);
    logic [GP_WIDTH-1:0] m;
    m = '0;
    if (b == 0) begin
      m[7] = 1'b1;
      m[8] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned W        = GP_WIDTH,
  parameter int unsigned AW       = GP_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  data_o,
  output logic [W-1:0]  oe_o,
  output logic [W-1:0]  rd_data
);

  localparam int unsigned HALF = W / 2;
  localparam logic [W-1:0] IMPL  = impl_mask(BANK_IDX);
  localparam logic [W-1:0] FIXED = fixed_dir(BANK_IDX);

  localparam logic [AW-1:0] A_LO  = AW'(8 * BANK_IDX);
  localparam logic [AW-1:0] A_HI  = AW'(8 * BANK_IDX + 4);
  localparam logic [AW-1:0] A_VAL = AW'(32'h060 + 4 * BANK_IDX);
  localparam logic [AW-1:0] A_DIR = AW'(32'h204 + 32'h40 * BANK_IDX);
  localparam logic [AW-1:0] A_OEN = AW'(32'h208 + 32'h40 * BANK_IDX);

  logic [W-1:0] data_q, data_d;
  logic [W-1:0] dir_q,  dir_d;
  logic [W-1:0] oen_q,  oen_d;
  logic         wr_lo, wr_hi, wr_dir, wr_oen;

  assign wr_lo  = wr_en && (addr == A_LO);
  assign wr_hi  = wr_en && (addr == A_HI);
  assign wr_dir = wr_en && (addr == A_DIR);
  assign wr_oen = wr_en && (addr == A_OEN);

  // next-state: masked half-word merge plus plain register writes
  always_comb begin
    data_d = data_q;
    for (int unsigned i = 0; i < HALF; i++) begin
      if (wr_lo && !wdata[HALF+i]) data_d[i]      = wdata[i];
      if (wr_hi && !wdata[HALF+i]) data_d[HALF+i] = wdata[i];
    end
    data_d = data_d & IMPL;

    dir_d = dir_q;
    if (wr_dir) dir_d = wdata;
    dir_d = (dir_d & IMPL) | FIXED;

    oen_d = oen_q;
    if (wr_oen) oen_d = wdata;
    oen_d = oen_d & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= FIXED;
      oen_q  <= '0;
    end else begin
      if (wr_lo || wr_hi) data_q <= data_d;
      if (wr_dir)         dir_q  <= dir_d;
      if (wr_oen)         oen_q  <= oen_d;
    end
  end

  assign data_o = data_q;
  assign oe_o   = dir_q & oen_q;

  always_comb begin
    if (addr == A_VAL)      rd_data = pin_sync & IMPL;
    else if (addr == A_DIR) rd_data = dir_q;
    else if (addr == A_OEN) rd_data = oen_q;
    else                    rd_data = '0;
  end

  // R1: bits under a set mask keep their value across a low-half write
  p_lo_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (((data_q[HALF-1:0] ^ $past(data_q[HALF-1:0]))
               & $past(wdata[W-1:HALF])) == '0));

  // R2: the upper half follows the same rule, and a low write leaves it alone
  p_hi_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi || wr_lo) |=> (((data_q[W-1:HALF] ^ $past(data_q[W-1:HALF]))
               & ($past(wr_lo) ? {HALF{1'b1}} : $past(wdata[W-1:HALF]))) == '0));

  // R7: unimplemented pins never drive or hold a value
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_o | oe_o | dir_q | oen_q) & ~IMPL) == '0);

  // R8: locked direction bits stay at output
  p_fixed_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & FIXED) == FIXED);

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned BANKS = GP_BANKS,
  parameter int unsigned W     = GP_WIDTH,
  parameter int unsigned AW    = GP_ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [W-1:0]        req_wdata,
  output logic                rsp_valid,
  output logic [W-1:0]        rsp_rdata,
  input  logic [BANKS*W-1:0]  pin_in,
  output logic [BANKS*W-1:0]  pin_out,
  output logic [BANKS*W-1:0]  pin_oe
);

  localparam int unsigned NPIN = BANKS * W;

  logic [NPIN-1:0] pins_sync;
  logic [W-1:0]    bank_rd [BANKS];
  logic            wr_en, rd_en;
  logic [W-1:0]    rd_mux;
  logic [W-1:0]    rdata_d;
  logic            rsp_valid_q;
  logic [W-1:0]    rsp_rdata_q;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pins_sync)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_bank #(.BANK_IDX(b), .W(W), .AW(AW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (req_addr),
      .wdata    (req_wdata),
      .pin_sync (pins_sync[b*W +: W]),
      .data_o   (pin_out[b*W +: W]),
      .oe_o     (pin_oe[b*W +: W]),
      .rd_data  (bank_rd[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int unsigned b = 0; b < BANKS; b++) rd_mux = rd_mux | bank_rd[b];
    rdata_d = rd_en ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R10: masked-data and low unmapped offsets answer with zero
  p_wo_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (req_addr < AW'(8 * BANKS))) |=> (rsp_rdata == '0));

  // R11: no response data appears without a read
  p_idle_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));

endmodule

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [127:0]  pin_in = '0;
  logic [127:0]  pin_out;
  logic [127:0]  pin_oe;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] m_data [4];
  logic [31:0] m_dir  [4];
  logic [31:0] m_oen  [4];

  always #4 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] b_impl(int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] b_fix(int b);
    return (b == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_data[b] = '0; m_dir[b] = b_fix(b); m_oen[b] = '0;
    end
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      if (a == 12'(8*b)) begin
        for (int i = 0; i < 16; i++) if (!d[16+i]) m_data[b][i] = d[i];
      end
      if (a == 12'(8*b+4)) begin
        for (int i = 0; i < 16; i++) if (!d[16+i]) m_data[b][16+i] = d[i];
      end
      if (a == 12'(12'h204 + 12'h40*b)) m_dir[b] = d;
      if (a == 12'(12'h208 + 12'h40*b)) m_oen[b] = d;
      m_data[b] = m_data[b] & b_impl(b);
      m_dir[b]  = (m_dir[b] & b_impl(b)) | b_fix(b);
      m_oen[b]  = m_oen[b] & b_impl(b);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    for (int b = 0; b < 4; b++) begin
      if (a == 12'(12'h060 + 4*b))        return pin_in[b*32 +: 32] & b_impl(b);
      if (a == 12'(12'h204 + 12'h40*b))   return m_dir[b];
      if (a == 12'(12'h208 + 12'h40*b))   return m_oen[b];
    end
    return '0;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(string req);
    logic [127:0] eo, ee;
    for (int b = 0; b < 4; b++) begin
      eo[b*32 +: 32] = m_data[b];
      ee[b*32 +: 32] = m_dir[b] & m_oen[b];
    end
    chk(pin_out == eo, {req, " pin_out"}, pin_out, eo);
    chk(pin_oe == ee, {req, " pin_oe"}, pin_oe, ee);
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
    chk(rsp_valid == 1'b0, "R11 no rsp after write", 128'(rsp_valid), 128'(0));
  endtask

  task automatic bus_rd(logic [11:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e = model_read(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R11 rsp_valid", 128'(rsp_valid), 128'(1));
    chk(rsp_rdata == e, req, 128'(rsp_rdata), 128'(e));
  endtask

  task automatic set_pins(logic [127:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_val;
    logic [11:0] addr_pick [12];
    seed_val = $urandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk_pins("R9 reset");
    bus_rd(12'h204, "R9 R8 bank0 dir reset");
    bus_rd(12'h244, "R9 bank1 dir reset");
    bus_rd(12'h2C8, "R9 bank3 oen reset");

    // R1 lower-half masked writes
    bus_wr(12'h010, 32'h0000_A5A5);
    chk_pins("R1 unmasked lower write");
    bus_wr(12'h010, 32'hFFFE_0000);
    chk_pins("R1 clear bit0 only");
    bus_wr(12'h010, 32'h0F0F_FFFF);
    chk_pins("R1 partial mask");

    // R2 upper-half masked writes
    bus_wr(12'h01C, 32'h00FF_1234);
    chk_pins("R2 upper half");
    bus_wr(12'h014, 32'h7FFF_FFFF);
    chk_pins("R2 set pin 31 only");

    // R3 R4 R5 drive enable needs both bits
    bus_wr(12'h288, 32'h0000_FFFF);
    chk_pins("R3 oen without dir");
    bus_wr(12'h284, 32'hFF00_FF00);
    chk_pins("R3 dir and oen");
    bus_rd(12'h284, "R4 dir readback");
    bus_rd(12'h288, "R5 oen readback");

    // R8 locked direction bits
    bus_wr(12'h204, 32'h0);
    bus_rd(12'h204, "R8 locked bits after write 0");
    bus_wr(12'h208, 32'hFFFF_FFFF);
    chk_pins("R8 bank0 drives locked pins");

    // R7 bank1 unimplemented bits
    bus_wr(12'h244, 32'hFFFF_FFFF);
    bus_rd(12'h244, "R7 bank1 dir upper zero");
    bus_wr(12'h248, 32'hFFFF_FFFF);
    bus_wr(12'h00C, 32'h0000_FFFF);
    chk_pins("R7 bank1 upper pins");
    chk(pin_out[63:54] == '0, "R7 pin_out 63:54", 128'(pin_out[63:54]), 128'(0));

    // R6 pin value reads
    set_pins({32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF, 32'h8000_0001});
    bus_rd(12'h060, "R6 bank0 value");
    bus_rd(12'h064, "R6 R7 bank1 value masked");
    bus_rd(12'h06C, "R6 bank3 value");

    // R10 write-only and unmapped offsets
    bus_rd(12'h000, "R10 read masked data");
    bus_rd(12'h100, "R10 read unmapped");
    bus_wr(12'h100, 32'h0000_FFFF);
    chk_pins("R10 unmapped write ignored");
    bus_wr(12'h064, 32'h0000_0000);
    bus_rd(12'h064, "R10 value write ignored");

    // random mix
    addr_pick = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                  12'h018, 12'h01C, 12'h204, 12'h248, 12'h284, 12'h2C8};
    for (int n = 0; n < 400; n++) begin
      int kind;
      int b;
      logic [11:0] a;
      kind = int'($urandom % 8);
      b = int'($urandom % 4);
      if (kind < 4) begin
        a = addr_pick[$urandom % 12];
        bus_wr(a, $urandom);
        chk_pins("R1 R2 random write");
      end else if (kind == 4) begin
        bus_wr((b[0]) ? 12'(12'h204 + 12'h40*b) : 12'(12'h208 + 12'h40*b), $urandom);
        chk_pins("R3 random cfg");
      end else if (kind == 5) begin
        bus_rd((b[0]) ? 12'(12'h204 + 12'h40*b) : 12'(12'h208 + 12'h40*b),
               "R4 R5 random readback");
      end else if (kind == 6) begin
        set_pins({$urandom, $urandom, $urandom, $urandom});
        bus_rd(12'(12'h060 + 4*b), "R6 random value");
      end else begin
        a = 12'(($urandom % 1024) * 4);
        bus_wr(a, $urandom);
        chk_pins("R10 random offset write");
        bus_rd(a, "R10 random offset read");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule